// File: doc/BRIEF.md
# Clock Output Mode and State Controller

This block sits between the frequency synthesis stage of a clock generator and its output driver. A three-bit mode word picks which internal clock reaches the output: the multiplied clock with the phase aligner in use, the multiplied clock with the aligner bypassed, the divided clock with the aligner in use, or the raw reference in a test bypass. A power-down input and an output-stop input then decide whether that clock is driven, forced low or parked at a stop level. The block also tells the driver when to float its pins.

The power-down and stop inputs are asynchronous to the block. Each passes through a two-flop synchroniser. All three candidate clocks are sampled in the block clock domain, which runs faster than any of them. The stop gate may open or close only while the sampled selected clock is low. An output high pulse is therefore never shortened. When the stop is released, the output comes back in phase with the source, because the source itself never stops running.

A status word reports the resolved state. A decoded divide ratio and an aligner-enable flag are provided for the neighbouring divider and aligner.

Top module: `clkgen_out_ctrl`

## Requirements
- R1: Mode 3'b000 selects the multiplied clock, sets `align_en` to 1 and reports status 4 (multiply).
- R2: Mode 3'b001 selects the divided clock, sets `align_en` to 1 and reports status 6 (divide). `div_ratio` decodes `div_code` as follows: 2'b00 gives 2, 2'b10 gives 3, 2'b11 gives 4, and the reserved code 2'b01 gives 0. In every other mode `div_ratio` is 0.
- R3: Mode 3'b100 selects the multiplied clock, sets `align_en` to 0 and reports status 5 (multiply, aligner bypassed).
- R4: Mode 3'b110 routes `ref_clk` to the output, sets `align_en` to 0 and reports status 3 (test).
- R5: Modes 3'b010, 3'b011, 3'b101 and 3'b111 report status 2 (high impedance), whatever the stop input is. In these modes `out_oe` is 0 and both outputs are 0.
- R6: With `pwrdn_n` low, the block behaves as follows once the two-cycle synchroniser has passed the level: status is 0, `force_low` is 1, both outputs are 0 and `out_oe` is 1. This holds whatever the stop input and the mode are.
- R7: With `stop_n` low and power on, the block waits for the sampled source to be low. It then reports status 1, sets `stop_hold` to 1 and holds both outputs at 0. Every high pulse on `out_p` lasts exactly one full source high phase.
- R8: After `stop_n` returns high, `out_p` rises again within 20 block clock cycles. It then tracks the source with no shortened pulse.
- R9: While running, `out_p` equals the selected source as it was sampled two block clock edges earlier, and `out_n` is its complement.
- R10: During and just after reset, status is 0 (power-down), both outputs are 0 and `force_low` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than any source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Mode select word, first digit is bit 2 |
| div_code | input | 2 | Divide ratio code |
| pwrdn_n | input | 1 | Active-low power-down, asynchronous |
| stop_n | input | 1 | Active-low output stop, asynchronous |
| mul_clk | input | 1 | Multiplied clock from the synthesiser |
| div_clk | input | 1 | Divided clock from the synthesiser |
| ref_clk | input | 1 | Raw reference clock |
| out_p | output | 1 | Gated clock, true side |
| out_n | output | 1 | Gated clock, complement side |
| out_oe | output | 1 | Driver enable, 0 floats both pins |
| force_low | output | 1 | Power-down, driver pulls both pins to ground |
| stop_hold | output | 1 | Stopped, driver holds the stop level |
| align_en | output | 1 | Phase aligner and delay stepping enabled |
| div_ratio | output | 3 | Decoded divide ratio, 0 when unused |
| state | output | 3 | Status: 0 power-down, 1 stopped, 2 Hi-Z, 3 test, 4 multiply, 5 multiply bypass, 6 divide |

## Verification
The bench drops `stop_n` at two different points of the source waveform, one of them in the middle of a high phase. A gate that closes without waiting for the source to go low leaves a shortened final pulse, and the pulse-length monitor catches it. After the stop is released, the bench measures the restart delay and compares the output with the delayed source cycle by cycle. A gate that reopens at the wrong moment, or a path that loses its phase, shows up as a late restart or a mismatch. The bench also asserts power-down together with a low stop input, and holds the stop low in the Hi-Z modes. A design that lets the stop win, or that decodes the reserved mode codes as clocking modes, reports the wrong status or drives the pins.

// File: rtl/cgo_pkg.sv
// Shared types for the clock output controller.
// Assumes: status values are read by software-visible logic elsewhere, so
// the encoding is fixed.
package cgo_pkg;
    typedef enum logic [2:0] {
        ST_PDOWN  = 3'd0,
        ST_STOP   = 3'd1,
        ST_HIZ    = 3'd2,
        ST_TEST   = 3'd3,
        ST_MUL    = 3'd4,
        ST_MULBYP = 3'd5,
        ST_DIV    = 3'd6
    } cgo_state_e;

    typedef enum logic [1:0] {
        SRC_MUL  = 2'd0,
        SRC_DIV  = 2'd1,
        SRC_REF  = 2'd2,
        SRC_NONE = 2'd3
    } cgo_src_e;
endpackage

// File: rtl/cgo_sync.sv
// Multi-bit level synchroniser. Each bit passes through STAGES flops.
// Assumes: each bit is an independent slow level, so no bus coherence is needed.
module cgo_sync #(
    parameter int WIDTH   = 2,
    parameter int STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage captures the asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Each further stage re-times the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cgo_mode_dec.sv
// Mode decoder. Maps the mode word to a source choice, the aligner enable,
// the Hi-Z request and the running status class. Also decodes the divide
// ratio code.
// Assumes: mode and div_code are quasi-static configuration.
module cgo_mode_dec
    import cgo_pkg::*;
#(
    parameter int RATIO_W = 3
) (
    input  logic [2:0]         mode,
    input  logic [1:0]         div_code,
    output cgo_src_e           src,
    output logic               hiz,
    output logic               align_en,
    output logic [RATIO_W-1:0] div_ratio,
    output cgo_state_e         run_class
);
    logic [RATIO_W-1:0] ratio_raw;

    // Ratio code 01 is reserved and reads back as 0.
    always_comb begin
        unique case (div_code)
            2'b00:   ratio_raw = RATIO_W'(2);
            2'b10:   ratio_raw = RATIO_W'(3);
            2'b11:   ratio_raw = RATIO_W'(4);
            default: ratio_raw = '0;
        endcase
    end

    // Mode table. Every code that is not listed floats the outputs.
    always_comb begin
        src       = SRC_NONE;
        hiz       = 1'b0;
        align_en  = 1'b0;
        div_ratio = '0;
        run_class = ST_HIZ;
        unique case (mode)
            3'b000: begin src = SRC_MUL; align_en = 1'b1; run_class = ST_MUL; end
            3'b001: begin
                src = SRC_DIV; align_en = 1'b1; run_class = ST_DIV;
                div_ratio = ratio_raw;
            end
            3'b100: begin src = SRC_MUL; run_class = ST_MULBYP; end
            3'b110: begin src = SRC_REF; run_class = ST_TEST; end
            default: hiz = 1'b1;
        endcase
    end
endmodule

// File: rtl/cgo_gate.sv
// Glitch-free output gate. Samples the selected clock in the block clock
// domain and lets the stop gate change only while the sample is low.
// Whole high pulses are therefore passed or withheld.
// Assumes: clk is at least twice as fast as the selected source.
module cgo_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic src_in,
    input  logic stop_ok,
    input  logic run,
    output logic out_p,
    output logic out_n,
    output logic gate_open
);
    logic src_q;
    logic gate_d;

    // The gate follows the stop request only between source high phases.
    always_comb gate_d = src_q ? gate_open : stop_ok;

    // Sample the source, update the gate and drive the complementary pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q     <= 1'b0;
            gate_open <= 1'b0;
            out_p     <= 1'b0;
            out_n     <= 1'b0;
        end else begin
            src_q     <= src_in;
            gate_open <= gate_d;
            out_p     <= run & gate_d & src_q;
            out_n     <= run & gate_d & ~src_q;
        end
    end

    // R7: while power stays on, out_p falls only after the source sample fell.
    assert_no_runt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(out_p) && $past(run)) |-> !$past(src_q));

    // R8: the gate opens or closes only on an edge that saw the source low.
    assert_gate_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gate_open) |-> !$past(src_q));

    // R7: a closed gate keeps both outputs low.
    assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |-> (!out_p && !out_n));
endmodule

// File: rtl/clkgen_out_ctrl.sv
// Top of the clock output controller. Synchronises power-down and stop,
// decodes the mode, picks the source, gates it, and resolves the status.
// Status priority: power-down, then Hi-Z, then stopped, then the running class.
// Assumes: the source clocks are free-running and slower than clk / 2.
module clkgen_out_ctrl
    import cgo_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RATIO_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mode,
    input  logic [1:0]         div_code,
    input  logic               pwrdn_n,
    input  logic               stop_n,
    input  logic               mul_clk,
    input  logic               div_clk,
    input  logic               ref_clk,
    output logic               out_p,
    output logic               out_n,
    output logic               out_oe,
    output logic               force_low,
    output logic               stop_hold,
    output logic               align_en,
    output logic [RATIO_W-1:0] div_ratio,
    output logic [2:0]         state
);
    logic [1:0] ctl_s;
    logic       pwr_ok;
    logic       stop_ok;
    logic       hiz;
    logic       run;
    logic       src_sel;
    logic       gate_open;
    cgo_src_e   src;
    cgo_state_e run_class;
    cgo_state_e st;

    cgo_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({pwrdn_n, stop_n}), .q(ctl_s)
    );
    assign pwr_ok  = ctl_s[1];
    assign stop_ok = ctl_s[0];

    cgo_mode_dec #(.RATIO_W(RATIO_W)) u_dec (
        .mode(mode), .div_code(div_code), .src(src), .hiz(hiz),
        .align_en(align_en), .div_ratio(div_ratio), .run_class(run_class)
    );

    // Source multiplexer driven by the decoded choice.
    always_comb begin
        unique case (src)
            SRC_MUL: src_sel = mul_clk;
            SRC_DIV: src_sel = div_clk;
            SRC_REF: src_sel = ref_clk;
            default: src_sel = 1'b0;
        endcase
    end

    assign run = pwr_ok & ~hiz;

    cgo_gate u_gate (
        .clk(clk), .rst_n(rst_n), .src_in(src_sel), .stop_ok(stop_ok),
        .run(run), .out_p(out_p), .out_n(out_n), .gate_open(gate_open)
    );

    // Resolve the reported state by priority.
    always_comb begin
        if (!pwr_ok)         st = ST_PDOWN;
        else if (hiz)        st = ST_HIZ;
        else if (!gate_open) st = ST_STOP;
        else                 st = run_class;
    end

    assign state     = st;
    assign force_low = ~pwr_ok;
    assign out_oe    = ~(pwr_ok & hiz);
    assign stop_hold = run & ~gate_open;

    // R6: a power-down that lasted two cycles leaves both pins low and driven.
    assert_pdown_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd0 && $past(state) == 3'd0) |-> (!out_p && !out_n && force_low && out_oe));

    // R5: the Hi-Z status always comes with the driver released.
    assert_hiz_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd2) |-> !out_oe);
endmodule

// File: tb/test_clkgen_out_ctrl.sv
`timescale 1ns/1ps
module test_clkgen_out_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'b000;
    logic [1:0] div_code = 2'b00;
    logic       pwrdn_n = 1'b1;
    logic       stop_n = 1'b1;
    logic       mul_clk, div_clk, ref_clk;
    logic       out_p, out_n, out_oe, force_low, stop_hold, align_en;
    logic [2:0] div_ratio;
    logic [2:0] state;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    // Free-running sources, changed on the falling edge of clk.
    int unsigned cnt = 0;
    always @(negedge clk) cnt <= cnt + 1;
    assign mul_clk = (cnt % 8)  < 4;
    assign div_clk = (cnt % 12) < 6;
    assign ref_clk = (cnt % 6)  < 3;

    // Source the bench expects for the current mode, and its high length.
    logic exp_src;
    int   exp_half;
    always_comb begin
        case (mode)
            3'b001:  begin exp_src = div_clk; exp_half = 6; end
            3'b110:  begin exp_src = ref_clk; exp_half = 3; end
            default: begin exp_src = mul_clk; exp_half = 4; end
        endcase
    end

    // Two-edge history of the expected source.
    logic h1 = 0, h2 = 0;
    always @(posedge clk) begin
        h1 <= exp_src;
        h2 <= h1;
    end

    // Pulse-length monitor: counts high pulses of the wrong length.
    bit mon_en = 0;
    int runt_err = 0;
    int plen = 0;
    bit pval = 0;
    bit prev_p = 0;
    always @(negedge clk) begin
        if (out_p && !prev_p) begin
            plen = 1;
            pval = mon_en;
        end else if (out_p) begin
            plen++;
        end else if (prev_p && pval && plen != exp_half) begin
            runt_err++;
        end
        prev_p = out_p;
    end

    clkgen_out_ctrl i_clkgen_out_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .div_code(div_code),
        .pwrdn_n(pwrdn_n), .stop_n(stop_n), .mul_clk(mul_clk),
        .div_clk(div_clk), .ref_clk(ref_clk), .out_p(out_p), .out_n(out_n),
        .out_oe(out_oe), .force_low(force_low), .stop_hold(stop_hold),
        .align_en(align_en), .div_ratio(div_ratio), .state(state)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Follow check: out_p equals the delayed source, out_n its complement.
    task automatic check_follow(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (out_p !== h2 || out_n !== !h2) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset();
        wait_cyc(3);
        chk(state == 3'd0 && !out_p && !out_n && force_low, "R10 reset state", state, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(state == 3'd0 && force_low && !out_p, "R10 after reset", state, 0);
    endtask

    task automatic t_run_mode(input logic [2:0] m, input int exp_st, input bit exp_al,
                              input string req);
        @(negedge clk) begin mode = m; mon_en = 0; end
        wait_cyc(20);
        mon_en = 1;
        runt_err = 0;
        chk(state == 3'(exp_st), {req, " status"}, state, exp_st);
        chk(align_en == exp_al && out_oe, {req, " aligner enable"}, align_en, exp_al);
        check_follow(30, {req, " R9 follows source"});
        chk(runt_err == 0, {req, " pulse length"}, runt_err, 0);
        chk(div_ratio == 3'd0 || m == 3'b001, "R2 ratio zero outside divide", div_ratio, 0);
    endtask

    task automatic t_div_codes();
        @(negedge clk) mode = 3'b001;
        div_code = 2'b00; #1 chk(div_ratio == 3'd2, "R2 code 00", div_ratio, 2);
        div_code = 2'b10; #1 chk(div_ratio == 3'd3, "R2 code 10", div_ratio, 3);
        div_code = 2'b11; #1 chk(div_ratio == 3'd4, "R2 code 11", div_ratio, 4);
        div_code = 2'b01; #1 chk(div_ratio == 3'd0, "R2 code 01 reserved", div_ratio, 0);
        div_code = 2'b00;
        @(negedge clk) mode = 3'b000;
        #1 chk(div_ratio == 3'd0, "R2 ratio in multiply mode", div_ratio, 0);
    endtask

    task automatic t_hiz();
        logic [2:0] codes [4] = '{3'b010, 3'b011, 3'b101, 3'b111};
        mon_en = 0;
        foreach (codes[i]) begin
            @(negedge clk) mode = codes[i];
            wait_cyc(3);
            chk(state == 3'd2 && !out_oe && !out_p && !out_n, "R5 hi-z mode", state, 2);
        end
        @(negedge clk) stop_n = 1'b0;
        wait_cyc(12);
        chk(state == 3'd2 && !out_oe, "R5 hi-z wins over stop", state, 2);
        @(negedge clk) begin stop_n = 1'b1; mode = 3'b000; end
        wait_cyc(20);
    endtask

    task automatic t_stop(input int phase);
        int dly = 0;
        @(negedge clk) mode = 3'b000;
        wait_cyc(20);
        while ((cnt % 8) != phase) @(negedge clk);
        mon_en = 1;
        runt_err = 0;
        stop_n = 1'b0;
        wait_cyc(14);
        chk(state == 3'd1 && stop_hold && !out_p && !out_n, "R7 stopped state", state, 1);
        chk(runt_err == 0, "R7 no shortened pulse on stop", runt_err, 0);
        wait_cyc(5);
        stop_n = 1'b1;
        while (!out_p && dly < 40) begin
            @(negedge clk);
            dly++;
        end
        chk(dly <= 20, "R8 restart delay", dly, 20);
        check_follow(24, "R8 phase after restart");
        chk(runt_err == 0 && state == 3'd4, "R8 whole pulses after restart", runt_err, 0);
    endtask

    task automatic t_pdown();
        mon_en = 0;
        @(negedge clk) begin pwrdn_n = 1'b0; stop_n = 1'b0; end
        wait_cyc(4);
        chk(state == 3'd0 && force_low && out_oe && !out_p && !out_n,
            "R6 power-down with stop low", state, 0);
        @(negedge clk) mode = 3'b011;
        wait_cyc(3);
        chk(state == 3'd0 && out_oe && !out_p, "R6 power-down over hi-z", state, 0);
        @(negedge clk) begin mode = 3'b000; pwrdn_n = 1'b1; end
        wait_cyc(6);
        chk(state == 3'd1 && !force_low && stop_hold, "R6 power up into stop", state, 1);
        @(negedge clk) stop_n = 1'b1;
        wait_cyc(20);
        chk(state == 3'd4, "R6 back to running", state, 4);
    endtask

    initial begin
        t_reset();
        wait_cyc(20);
        t_run_mode(3'b000, 4, 1'b1, "R1 multiply");
        t_run_mode(3'b001, 6, 1'b1, "R2 divide");
        t_run_mode(3'b100, 5, 1'b0, "R3 multiply bypass");
        t_run_mode(3'b110, 3, 1'b0, "R4 test bypass");
        t_div_codes();
        t_hiz();
        t_stop(1);
        t_stop(6);
        t_pdown();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule